// File: doc/BRIEF.md
# Four-Port Repeater Symbol Switch

This block is the switching core of a half-duplex repeater hub that works directly on 5-bit line symbols. Each port brings in one received symbol per clock and a link-good flag. Each port sends out one transmit symbol per clock. The all-ones symbol (0x1F) marks a quiet line. A port with a good link that receives any other symbol is counted as carrying a packet.

When a single port carries a packet, its symbols are repeated on every other port with a good link, one clock later. The sending port gets idle symbols back, so that its own traffic is not echoed. When two or more ports are busy in the same cycle, the block first forwards the lowest-numbered busy port for one cycle. It then enters a collision state. In that state every linked output carries a fixed jam symbol until every port has gone quiet again.

Active-low LED outputs show receive activity and link state for each port, and one more shows a collision. All outputs are registered. A synchronous active-low reset puts every output into its quiet state.

Top module: `rep_symbol_switch`

## Requirements
- R1: While `rst_n` is low at a clock edge, every transmit symbol becomes 0x1F and every LED output (`rx_led_n`, `link_led_n`, `coll_led_n`) becomes 1 (off).
- R2: A port counts as busy in a cycle only if its `link_ok` bit is 1 and its received symbol differs from 0x1F. Port i uses bits [5i+4:5i] of `rx_sym` and of `tx_sym`.
- R3: Suppose exactly one port is busy in a cycle and no collision is in progress. One clock later, every other linked port transmits that port's received symbol, and the busy port itself transmits 0x1F.
- R4: Suppose no port is busy in a cycle and no collision is in progress. One clock later, every transmit symbol is 0x1F.
- R5: A port whose `link_ok` is 0 always transmits 0x1F one clock later, collisions included. Its received symbol never makes it busy, so it cannot cause a collision.
- R6: Suppose two or more ports are busy in a cycle and no collision is in progress. One clock later, the outputs forward the lowest-numbered busy port, as in R3, and a collision begins. `coll_led_n` goes low one clock after that.
- R7: While a collision is in progress and at least one port is busy, every linked port transmits the jam symbol 0x00 one clock later.
- R8: A collision ends on the first cycle in which no port is busy. One clock later, all transmit symbols are 0x1F. `coll_led_n` returns high one clock after that.
- R9: `rx_led_n[i]` equals the inverse of port i's busy state, one clock later.
- R10: `link_led_n[i]` equals the inverse of `link_ok[i]`, one clock later.
- R11: Forwarding follows a new symbol on every clock, so a sequence received on the busy port reappears unchanged, one cycle delayed, on the other ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local symbol clock, one symbol per cycle |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_sym | input | 20 | Received symbols, 5 bits per port, port 0 in the low bits |
| link_ok | input | 4 | Link-good flag per port |
| tx_sym | output | 20 | Transmit symbols, 5 bits per port, port 0 in the low bits |
| rx_led_n | output | 4 | Receive activity LED per port, active low |
| link_led_n | output | 4 | Link LED per port, active low |
| coll_led_n | output | 1 | Collision LED, active low |

## Verification
The bench builds the block with its default parameters: four ports, 5-bit symbols, idle code 0x1F and jam code 0x00. Four ports are enough to put two busy ports at non-adjacent indices, to drop one link while others forward or collide, and to see the lowest-index choice pick both port 0 and port 1. The 5-bit width lets each busy port send symbols that differ from the idle code and from the jam code, so forwarded data, idle and jam can be told apart on every output.

// File: rtl/rep_pkg.sv
package rep_pkg;

  // Number of set bits among the lowest n bits of v.
  function automatic int count_set(input logic [31:0] v, input int n);
    int c;
    c = 0;
    for (int k = 0; k < 32; k++) begin
      if (k < n && v[k]) c++;
    end
    return c;
  endfunction

  // Index of the lowest set bit among the lowest n bits (0 if none).
  function automatic int first_set(input logic [31:0] v, input int n);
    int idx;
    idx = 0;
    for (int k = 31; k >= 0; k--) begin
      if (k < n && v[k]) idx = k;
    end
    return idx;
  endfunction

  typedef enum logic [1:0] {
    LANE_QUIET = 2'd0,
    LANE_FWD   = 2'd1,
    LANE_JAM   = 2'd2
  } lane_mode_e;

endpackage

// File: rtl/rep_port_detect.sv
module rep_port_detect #(
  parameter int NPORTS = 4,
  parameter int SYM_W  = 5,
  parameter logic [SYM_W-1:0] IDLE_SYM = '1
) (
  input  logic [NPORTS*SYM_W-1:0] rx_sym,
  input  logic [NPORTS-1:0]       link_ok,
  output logic [NPORTS-1:0]       busy
);

  genvar g;
  generate
    for (g = 0; g < NPORTS; g++) begin : g_det
      logic [SYM_W-1:0] sym;
      assign sym     = rx_sym[g*SYM_W +: SYM_W];
      assign busy[g] = link_ok[g] && (sym != IDLE_SYM);
    end
  endgenerate

endmodule

// File: rtl/rep_arbiter.sv
module rep_arbiter #(
  parameter int NPORTS = 4,
  localparam int IDX_W = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPORTS-1:0] busy,
  output logic              any_busy,
  output logic              multi_busy,
  output logic [IDX_W-1:0]  win_idx,
  output logic [NPORTS-1:0] grant,
  output logic              coll_q,
  output logic              coll_led_n
);
  import rep_pkg::*;

  int busy_cnt;

  always_comb begin
    busy_cnt   = count_set(32'(busy), NPORTS);
    any_busy   = (busy_cnt != 0);
    multi_busy = (busy_cnt > 1);
    win_idx    = IDX_W'(first_set(32'(busy), NPORTS));
    grant      = '0;
    if (any_busy) grant[win_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      coll_q     <= 1'b0;
      coll_led_n <= 1'b1;
    end else begin
      coll_q     <= multi_busy || (coll_q && any_busy);
      coll_led_n <= ~coll_q;
    end
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R6
  AST_COLL_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    multi_busy |=> coll_q); // R6
  AST_COLL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (coll_q && !any_busy) |=> !coll_q); // R8

endmodule

// File: rtl/rep_tx_lane.sv
module rep_tx_lane #(
  parameter int SYM_W = 5,
  parameter logic [SYM_W-1:0] IDLE_SYM = '1,
  parameter logic [SYM_W-1:0] JAM_SYM  = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             link,
  input  logic             busy,
  input  logic             winner,
  input  logic             any_busy,
  input  logic             coll_q,
  input  logic [SYM_W-1:0] fwd_sym,
  output logic [SYM_W-1:0] tx,
  output logic             rx_led_n,
  output logic             link_led_n
);
  import rep_pkg::*;

  lane_mode_e mode;

  always_comb begin
    if (!link || !any_busy)  mode = LANE_QUIET;
    else if (coll_q)         mode = LANE_JAM;
    else if (winner)         mode = LANE_QUIET;
    else                     mode = LANE_FWD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx         <= IDLE_SYM;
      rx_led_n   <= 1'b1;
      link_led_n <= 1'b1;
    end else begin
      case (mode)
        LANE_FWD: tx <= fwd_sym;
        LANE_JAM: tx <= JAM_SYM;
        default:  tx <= IDLE_SYM;
      endcase
      rx_led_n   <= ~busy;
      link_led_n <= ~link;
    end
  end

  AST_LINK_DOWN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !link |=> (tx == IDLE_SYM)); // R5
  AST_WINNER_NO_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    (winner && !coll_q) |=> (tx == IDLE_SYM)); // R3
  AST_RX_LED_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !rx_led_n); // R9
  AST_LINK_LED_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    link |=> !link_led_n); // R10

endmodule

// File: rtl/rep_symbol_switch.sv
module rep_symbol_switch #(
  parameter int NPORTS = 4,
  parameter int SYM_W  = 5,
  parameter logic [SYM_W-1:0] IDLE_SYM = '1,
  parameter logic [SYM_W-1:0] JAM_SYM  = '0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPORTS*SYM_W-1:0] rx_sym,
  input  logic [NPORTS-1:0]       link_ok,
  output logic [NPORTS*SYM_W-1:0] tx_sym,
  output logic [NPORTS-1:0]       rx_led_n,
  output logic [NPORTS-1:0]       link_led_n,
  output logic                    coll_led_n
);

  localparam int IDX_W = (NPORTS > 1) ? $clog2(NPORTS) : 1;

  logic [NPORTS-1:0] busy;
  logic [NPORTS-1:0] grant;
  logic              any_busy;
  logic              multi_busy;
  logic              coll_q;
  logic [IDX_W-1:0]  win_idx;
  logic [SYM_W-1:0]  rx_arr [NPORTS];
  logic [SYM_W-1:0]  fwd_sym;

  rep_port_detect #(.NPORTS(NPORTS), .SYM_W(SYM_W), .IDLE_SYM(IDLE_SYM)) u_detect (
    .rx_sym  (rx_sym),
    .link_ok (link_ok),
    .busy    (busy)
  );

  rep_arbiter #(.NPORTS(NPORTS)) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .any_busy   (any_busy),
    .multi_busy (multi_busy),
    .win_idx    (win_idx),
    .grant      (grant),
    .coll_q     (coll_q),
    .coll_led_n (coll_led_n)
  );

  assign fwd_sym = rx_arr[win_idx];

  genvar g;
  generate
    for (g = 0; g < NPORTS; g++) begin : g_lane
      assign rx_arr[g] = rx_sym[g*SYM_W +: SYM_W];
      rep_tx_lane #(.SYM_W(SYM_W), .IDLE_SYM(IDLE_SYM), .JAM_SYM(JAM_SYM)) u_lane (
        .clk        (clk),
        .rst_n      (rst_n),
        .link       (link_ok[g]),
        .busy       (busy[g]),
        .winner     (grant[g]),
        .any_busy   (any_busy),
        .coll_q     (coll_q),
        .fwd_sym    (fwd_sym),
        .tx         (tx_sym[g*SYM_W +: SYM_W]),
        .rx_led_n   (rx_led_n[g]),
        .link_led_n (link_led_n[g])
      );
    end
  endgenerate

  AST_COLL_LED_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    coll_q |=> !coll_led_n); // R6
  AST_JAM_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (coll_q && any_busy && (&link_ok)) |=> (tx_sym == {NPORTS{JAM_SYM}})); // R7
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !any_busy |=> (tx_sym == {NPORTS{IDLE_SYM}})); // R4
  AST_NO_BUSY_UNLINKED: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(busy & ~link_ok) && ((busy & ~link_ok) == '0)); // R2

endmodule

// File: tb/rep_symbol_switch_tb.sv
module rep_symbol_switch_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] rx_sym = '1;
  logic [3:0]  link_ok = '0;
  logic [19:0] tx_sym;
  logic [3:0]  rx_led_n;
  logic [3:0]  link_led_n;
  logic        coll_led_n;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rep_symbol_switch u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_sym     (rx_sym),
    .link_ok    (link_ok),
    .tx_sym     (tx_sym),
    .rx_led_n   (rx_led_n),
    .link_led_n (link_led_n),
    .coll_led_n (coll_led_n)
  );

  function automatic logic [19:0] pk(input logic [4:0] p0, input logic [4:0] p1,
                                     input logic [4:0] p2, input logic [4:0] p3);
    return {p3, p2, p1, p0};
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; rx_sym = pk(5'h03, 5'h1F, 5'h1F, 5'h1F); link_ok = 4'hF;
    step(); step();
    chk("R1 tx under reset", 32'(tx_sym), 32'(pk(5'h1F, 5'h1F, 5'h1F, 5'h1F)));
    chk("R1 rx leds under reset", 32'(rx_led_n), 32'hF);
    chk("R1 link leds under reset", 32'(link_led_n), 32'hF);
    chk("R1 coll led under reset", 32'(coll_led_n), 32'h1);
    rx_sym = '1; rst_n = 1'b1;
  endtask

  task automatic t_idle();
    link_ok = 4'hF; rx_sym = '1;
    step();
    chk("R4 quiet tx", 32'(tx_sym), 32'(pk(5'h1F, 5'h1F, 5'h1F, 5'h1F)));
    chk("R10 link leds all up", 32'(link_led_n), 32'h0);
    chk("R9 rx leds quiet", 32'(rx_led_n), 32'hF);
  endtask

  task automatic t_single();
    logic [4:0] seq [3];
    seq[0] = 5'h0A; seq[1] = 5'h0B; seq[2] = 5'h15;
    link_ok = 4'hF;
    for (int k = 0; k < 3; k++) begin
      rx_sym = pk(5'h1F, 5'h1F, seq[k], 5'h1F);
      step();
      chk("R3 R11 single port forward", 32'(tx_sym), 32'(pk(seq[k], seq[k], 5'h1F, seq[k])));
    end
    chk("R9 rx led port2", 32'(rx_led_n), 32'hB);
    chk("R6 no collision on single", 32'(coll_led_n), 32'h1);
    rx_sym = '1;
    step();
    chk("R4 back to idle", 32'(tx_sym), 32'(pk(5'h1F, 5'h1F, 5'h1F, 5'h1F)));
  endtask

  task automatic t_link_down();
    link_ok = 4'b0111;
    rx_sym = pk(5'h1F, 5'h07, 5'h1F, 5'h05);
    step();
    chk("R5 R2 unlinked port ignored", 32'(tx_sym), 32'(pk(5'h07, 5'h1F, 5'h07, 5'h1F)));
    chk("R10 link led port3 off", 32'(link_led_n), 32'h8);
    chk("R2 rx led only port1", 32'(rx_led_n), 32'hD);
    step();
    chk("R5 no collision from unlinked", 32'(coll_led_n), 32'h1);
    rx_sym = '1; link_ok = 4'hF;
    step();
  endtask

  task automatic t_collision();
    link_ok = 4'b1110;
    rx_sym = pk(5'h09, 5'h03, 5'h1F, 5'h04);
    step();
    chk("R6 lowest busy forwarded first", 32'(tx_sym), 32'(pk(5'h1F, 5'h1F, 5'h03, 5'h03)));
    chk("R6 coll led not yet", 32'(coll_led_n), 32'h1);
    step();
    chk("R7 jam on linked ports", 32'(tx_sym), 32'(pk(5'h1F, 5'h00, 5'h00, 5'h00)));
    chk("R6 coll led on", 32'(coll_led_n), 32'h0);
    rx_sym = pk(5'h1F, 5'h1F, 5'h1F, 5'h04);
    step();
    chk("R7 jam holds with one busy", 32'(tx_sym), 32'(pk(5'h1F, 5'h00, 5'h00, 5'h00)));
    rx_sym = '1;
    step();
    chk("R8 idle after collision", 32'(tx_sym), 32'(pk(5'h1F, 5'h1F, 5'h1F, 5'h1F)));
    chk("R8 coll led still on", 32'(coll_led_n), 32'h0);
    step();
    chk("R8 coll led off", 32'(coll_led_n), 32'h1);
    link_ok = 4'hF;
  endtask

  task automatic t_priority();
    link_ok = 4'hF;
    rx_sym = pk(5'h11, 5'h1F, 5'h12, 5'h1F);
    step();
    chk("R6 port0 wins", 32'(tx_sym), 32'(pk(5'h1F, 5'h11, 5'h11, 5'h11)));
    step();
    chk("R7 jam all four", 32'(tx_sym), 32'(pk(5'h00, 5'h00, 5'h00, 5'h00)));
    rx_sym = '1;
    step(); step();
    chk("R8 recovered", 32'(coll_led_n), 32'h1);
  endtask

  task automatic t_reset_mid();
    link_ok = 4'hF;
    rx_sym = pk(5'h1F, 5'h1F, 5'h1F, 5'h02);
    step();
    chk("R3 port3 forward", 32'(tx_sym), 32'(pk(5'h02, 5'h02, 5'h02, 5'h1F)));
    rst_n = 1'b0;
    step();
    chk("R1 reset mid packet tx", 32'(tx_sym), 32'(pk(5'h1F, 5'h1F, 5'h1F, 5'h1F)));
    chk("R1 reset mid packet leds", 32'({rx_led_n, link_led_n}), 32'hFF);
    rst_n = 1'b1; rx_sym = '1;
    step();
  endtask

  initial begin
    t_reset();
    t_idle();
    t_single();
    t_link_down();
    t_collision();
    t_priority();
    t_reset_mid();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule